// File: doc/BRIEF.md
# Indexed Host Register Window for a Two-Channel Line Card

This block is the host-side front end of a two-channel digital line card. The host sees a 32-byte I/O window. The lower half is a small configuration region. It holds read-only identity bytes, an active-low interrupt status byte that shares its offset with a write-only control byte, a second control byte, and an index byte. The upper sixteen bytes form a data window. The data window is steered to one of five downstream targets by the value in the index byte: frame channel A, frame channel B, the line-transceiver FIFO, or the low or high bank of transceiver registers.

Host software picks a target by writing the index and then reaches up to sixteen registers of that target through the data window. The low four bits of the host address pass straight through as the target register address. Software uses the high transceiver bank for transceiver registers above 0x2F. The block also collects three interrupt sources (transceiver, frame controller, timer) into a status byte where a 0 marks an active source. It drives one interrupt line, which is gated by the enable and reset bits of the control byte. The downstream targets are outside this block.

Top module: `isdn_host_window`

## Requirements
- R1: After reset the index, both control bytes, `host_rdata` and `irq_out` are all zero.
- R2: Reading offset 0 returns the parameter CLASS_CODE and offset 1 returns REVISION; writes to these offsets change nothing.
- R3: Offset 4 is the index byte. It holds all 8 bits written and reads back unchanged, and it changes only when offset 4 is written.
- R4: A read or write at offsets 0x10 to 0x1F asserts exactly one bit of `dn_cs`, selected by the index: 0x00 gives bit 0 (channel A), 0x01 gives bit 1 (channel B), 0x02 gives bit 2 (FIFO), 0x04 gives bit 3 (low bank) and 0x06 gives bit 4 (high bank). `dn_addr` carries host address bits 3:0, and `dn_cs` is zero when no data-window access is in progress.
- R5: A data-window read returns the byte on the selected target's lane of `dn_rdata` (lane k is bits 8k+7:8k) on `host_rdata` one clock after the read cycle.
- R6: With any other index value, data-window reads return 0xFF and accesses assert neither `dn_cs`, `dn_rd` nor `dn_wr`.
- R7: Reading offset 2 returns bit 0 = NOT transceiver source, bit 1 = NOT frame source and bit 2 = NOT timer source, with bits 7:3 zero. A value of 0x07 means this card has no interrupt pending.
- R8: Writing offset 2 loads control 0. Bit 0 drives `card_rst`, bit 1 drives `timer_off`, bit 2 drives `timer_clr`, bit 3 is interrupt enable and bit 4 drives `test_flag`. The outputs take the new values one clock after the write.
- R9: Writing offset 3 loads `irq_line` from bits 3:0 and `serial_en` from bit 7. Reading offset 3 returns those fields in the same positions, with bits 6:4 zero.
- R10: `irq_out` is high one clock after a cycle in which interrupt enable is set, `card_rst` is low and at least one source is active; otherwise it is low.
- R11: While control 0 bit 0 (card reset) is set, `irq_out` stays low even with enable set and sources active.
- R12: Configuration offsets 5 to 15 read as 0xFF, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 5 | Byte offset inside the window |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data, valid the cycle after a read |
| dn_cs | output | 5 | One-hot target select during data-window access |
| dn_addr | output | 4 | Target register address |
| dn_wr | output | 1 | Write strobe to the selected target |
| dn_rd | output | 1 | Read strobe to the selected target |
| dn_wdata | output | 8 | Write data to the targets |
| dn_rdata | input | 40 | Read data lanes, one byte per target |
| src_xcvr | input | 1 | Transceiver interrupt source, active high |
| src_hdlc | input | 1 | Frame controller interrupt source, active high |
| src_timer | input | 1 | Timer interrupt source, active high |
| card_rst | output | 1 | Card reset from control 0 |
| timer_off | output | 1 | Timer disable from control 0 |
| timer_clr | output | 1 | Timer reset from control 0 |
| test_flag | output | 1 | Test bit from control 0 |
| irq_line | output | 4 | Interrupt line selection |
| serial_en | output | 1 | Serial link enable |
| irq_out | output | 1 | Shared interrupt request, active high |

## Verification
The bench steps through every defined index code and several undefined ones: 0x03, 0x05, 0x07 and 0x80. An index decoder that matches on too few bits would select a target for one of the undefined codes, or swap the two transceiver banks. The bench reads back the status byte for several source patterns, including none and all. A design that forgot the inversion would return 0x00 when idle, which software reads as every source firing. It also checks that `irq_out` rises exactly one clock after enable is set, and stays low while the card-reset bit is held, which catches a combinational or ungated interrupt path. Writes to the identity and undefined configuration offsets are followed by reads of every stored register, which exposes a decoder that lets them alias onto real registers.

// File: rtl/hwin_pkg.sv
`timescale 1ns/1ps
package hwin_pkg;
  localparam int HW_DW  = 8;          // host data width
  localparam int HW_AW  = 5;          // window address width (32 bytes)
  localparam int HW_OW  = HW_AW - 1;  // offset width inside each half
  localparam int N_TGT  = 5;          // downstream targets
  localparam int N_SRC  = 3;          // interrupt sources
  localparam int LINE_W = 4;

  localparam logic [HW_OW-1:0] OFF_CLASS = 4'd0;
  localparam logic [HW_OW-1:0] OFF_REV   = 4'd1;
  localparam logic [HW_OW-1:0] OFF_STAT  = 4'd2;
  localparam logic [HW_OW-1:0] OFF_CTL1  = 4'd3;
  localparam logic [HW_OW-1:0] OFF_IDX   = 4'd4;

  // control byte 0, bit 0 in the lowest position
  typedef struct packed {
    logic test;
    logic irq_en;
    logic tclr;
    logic toff;
    logic hold;
  } ctl0_t;

  // index code steering the data window to target k
  function automatic logic [HW_DW-1:0] tgt_code(input int k);
    case (k)
      0:       return 8'h00;  // channel A
      1:       return 8'h01;  // channel B
      2:       return 8'h02;  // transceiver FIFO
      3:       return 8'h04;  // transceiver low bank
      default: return 8'h06;  // transceiver high bank
    endcase
  endfunction
endpackage

// File: rtl/hwin_cfg.sv
`timescale 1ns/1ps
module hwin_cfg
  import hwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [HW_AW-1:0]  addr,
  input  logic              wr,
  input  logic [HW_DW-1:0]  wdata,
  output ctl0_t             ctl0,
  output logic [LINE_W-1:0] line,
  output logic              serial,
  output logic [HW_DW-1:0]  idx
);
  logic cfg_wr;
  assign cfg_wr = wr & ~addr[HW_AW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl0   <= '0;
      line   <= '0;
      serial <= 1'b0;
      idx    <= '0;
    end else if (cfg_wr) begin
      case (addr[HW_OW-1:0])
        OFF_STAT: ctl0 <= ctl0_t'(wdata[$bits(ctl0_t)-1:0]);
        OFF_CTL1: begin
          line   <= wdata[LINE_W-1:0];
          serial <= wdata[HW_DW-1];
        end
        OFF_IDX:  idx <= wdata;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/hwin_route.sv
`timescale 1ns/1ps
module hwin_route
  import hwin_pkg::*;
(
  input  logic [HW_DW-1:0] idx,
  input  logic             win,
  input  logic             rd,
  input  logic             wr,
  output logic [N_TGT-1:0] cs,
  output logic             hit
);
  logic [N_TGT-1:0] match;

  for (genvar k = 0; k < N_TGT; k++) begin : g_match
    assign match[k] = (idx == tgt_code(k));
  end

  assign hit = |match;
  assign cs  = (win && (rd || wr)) ? match : '0;
endmodule

// File: rtl/hwin_irq.sv
`timescale 1ns/1ps
module hwin_irq
  import hwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src,
  input  logic             en,
  input  logic             hold,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= en & ~hold & (|src);
  end
endmodule

// File: rtl/isdn_host_window.sv
`timescale 1ns/1ps
module isdn_host_window
  import hwin_pkg::*;
#(
  parameter logic [HW_DW-1:0] CLASS_CODE = 8'h05,
  parameter logic [HW_DW-1:0] REVISION   = 8'h02
)(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [HW_AW-1:0]       host_addr,
  input  logic                   host_wr,
  input  logic                   host_rd,
  input  logic [HW_DW-1:0]       host_wdata,
  output logic [HW_DW-1:0]       host_rdata,
  output logic [N_TGT-1:0]       dn_cs,
  output logic [HW_OW-1:0]       dn_addr,
  output logic                   dn_wr,
  output logic                   dn_rd,
  output logic [HW_DW-1:0]       dn_wdata,
  input  logic [N_TGT*HW_DW-1:0] dn_rdata,
  input  logic                   src_xcvr,
  input  logic                   src_hdlc,
  input  logic                   src_timer,
  output logic                   card_rst,
  output logic                   timer_off,
  output logic                   timer_clr,
  output logic                   test_flag,
  output logic [LINE_W-1:0]      irq_line,
  output logic                   serial_en,
  output logic                   irq_out
);
  ctl0_t            ctl0_q;
  logic [HW_DW-1:0] idx_q;
  logic             hit;
  logic             win;
  logic             irq_en_w;
  logic [N_SRC-1:0] src;
  logic [HW_DW-1:0] win_data, cfg_data, rd_next;

  assign win      = host_addr[HW_AW-1];
  assign src      = {src_timer, src_hdlc, src_xcvr};
  assign irq_en_w = ctl0_q.irq_en;

  hwin_cfg u_cfg (
    .clk, .rst,
    .addr  (host_addr),
    .wr    (host_wr),
    .wdata (host_wdata),
    .ctl0  (ctl0_q),
    .line  (irq_line),
    .serial(serial_en),
    .idx   (idx_q)
  );

  hwin_route u_route (
    .idx (idx_q),
    .win (win),
    .rd  (host_rd),
    .wr  (host_wr),
    .cs  (dn_cs),
    .hit (hit)
  );

  hwin_irq u_irq (
    .clk, .rst,
    .src  (src),
    .en   (ctl0_q.irq_en),
    .hold (ctl0_q.hold),
    .irq  (irq_out)
  );

  assign dn_addr   = host_addr[HW_OW-1:0];
  assign dn_wdata  = host_wdata;
  assign dn_wr     = host_wr & (|dn_cs);
  assign dn_rd     = host_rd & (|dn_cs);
  assign card_rst  = ctl0_q.hold;
  assign timer_off = ctl0_q.toff;
  assign timer_clr = ctl0_q.tclr;
  assign test_flag = ctl0_q.test;

  // lane select from the one-hot chip select
  always_comb begin
    win_data = '0;
    for (int k = 0; k < N_TGT; k++)
      if (dn_cs[k]) win_data = win_data | dn_rdata[k*HW_DW +: HW_DW];
  end

  always_comb begin
    case (host_addr[HW_OW-1:0])
      OFF_CLASS: cfg_data = CLASS_CODE;
      OFF_REV:   cfg_data = REVISION;
      OFF_STAT:  cfg_data = {{(HW_DW-N_SRC){1'b0}}, ~src};
      OFF_CTL1:  cfg_data = {serial_en, {(HW_DW-LINE_W-1){1'b0}}, irq_line};
      OFF_IDX:   cfg_data = idx_q;
      default:   cfg_data = '1;
    endcase
  end

  assign rd_next = win ? (hit ? win_data : '1) : cfg_data;

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_next;
  end
endmodule

// File: rtl/hwin_chk.sv
`timescale 1ns/1ps
module hwin_chk
  import hwin_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [HW_AW-1:0] host_addr,
  input logic             host_rd,
  input logic             host_wr,
  input logic [N_TGT-1:0] dn_cs,
  input logic [HW_DW-1:0] idx_q,
  input logic             irq_en_w,
  input logic             card_rst,
  input logic             src_xcvr,
  input logic             src_hdlc,
  input logic             src_timer,
  input logic             irq_out
);
  logic undef_idx;
  assign undef_idx = (idx_q != 8'h00) && (idx_q != 8'h01) && (idx_q != 8'h02) &&
                     (idx_q != 8'h04) && (idx_q != 8'h06);

  p_cs_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dn_cs));

  p_cs_access_r4: assert property (@(posedge clk) disable iff (rst)
    (|dn_cs) |-> (host_addr[HW_AW-1] && (host_rd || host_wr)));

  p_undef_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    undef_idx |-> (dn_cs == '0));

  p_idx_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && host_addr == 5'd4) |=> $stable(idx_q));

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(irq_en_w && !card_rst && (src_xcvr || src_hdlc || src_timer)));

  p_rst_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    card_rst |=> !irq_out);
endmodule

bind isdn_host_window hwin_chk u_hwin_chk (
  .clk       (clk),
  .rst       (rst),
  .host_addr (host_addr),
  .host_rd   (host_rd),
  .host_wr   (host_wr),
  .dn_cs     (dn_cs),
  .idx_q     (idx_q),
  .irq_en_w  (irq_en_w),
  .card_rst  (card_rst),
  .src_xcvr  (src_xcvr),
  .src_hdlc  (src_hdlc),
  .src_timer (src_timer),
  .irq_out   (irq_out)
);

// File: tb/test_isdn_host_window.sv
`timescale 1ns/1ps
module test_isdn_host_window;
  localparam logic [7:0] CLS = 8'h05;
  localparam logic [7:0] REV = 8'h02;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [4:0]  dn_cs;
  logic [3:0]  dn_addr;
  logic        dn_wr, dn_rd;
  logic [7:0]  dn_wdata;
  logic [39:0] dn_rdata;
  logic        src_xcvr = 1'b0, src_hdlc = 1'b0, src_timer = 1'b0;
  logic        card_rst, timer_off, timer_clr, test_flag, serial_en, irq_out;
  logic [3:0]  irq_line;

  int total = 0;
  int bad   = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_d = 1'b0;
  logic [7:0] codes [5] = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h06};

  always #2 clk = ~clk;  // 250 MHz

  // stub targets: lane k returns {0xA+k, register address}
  always_comb
    for (int k = 0; k < 5; k++) dn_rdata[k*8 +: 8] = {4'(4'hA + k), dn_addr};

  isdn_host_window #(.CLASS_CODE(CLS), .REVISION(REV)) i_isdn_host_window (
    .clk, .rst, .host_addr, .host_wr, .host_rd, .host_wdata, .host_rdata,
    .dn_cs, .dn_addr, .dn_wr, .dn_rd, .dn_wdata, .dn_rdata,
    .src_xcvr, .src_hdlc, .src_timer,
    .card_rst, .timer_off, .timer_clr, .test_flag, .irq_line, .serial_en, .irq_out
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected byte per completed read
  always @(posedge clk) rd_d <= host_rd;
  always @(negedge clk) begin
    if (rd_d && !rst) begin
      if (exp_q.size() == 0) check("scoreboard empty", 32'd1, 32'd0);
      else check(tag_q.pop_front(), 32'(host_rdata), 32'(exp_q.pop_front()));
    end
  end

  task automatic hw_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hw_read(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic win_write_chk(input logic [4:0] a, input logic [7:0] d,
                               input logic [4:0] exp_cs, input string tag);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    #0.5;
    check(tag, {dn_cs, dn_addr, dn_wr}, {exp_cs, a[3:0], |exp_cs});
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rdata", 32'(host_rdata), 32'h0);
    check("R1 irq", 32'(irq_out), 32'h0);
    check("R1 ctl outputs", {card_rst, timer_off, timer_clr, test_flag, irq_line, serial_en}, 32'h0);
    hw_read(5'h04, 8'h00, "R1 index reset");
    hw_read(5'h03, 8'h00, "R1 ctl1 reset");
    check("R1 idle cs", 32'(dn_cs), 32'h0);

    // R2 identity
    hw_read(5'h00, CLS, "R2 class");
    hw_read(5'h01, REV, "R2 revision");
    hw_write(5'h00, 8'h77);
    hw_write(5'h01, 8'h66);
    hw_read(5'h00, CLS, "R2 class after write");
    hw_read(5'h01, REV, "R2 revision after write");

    // R3 index readback
    hw_write(5'h04, 8'h5A);
    hw_read(5'h04, 8'h5A, "R3 index readback");
    hw_write(5'h04, 8'hC3);
    hw_read(5'h04, 8'hC3, "R3 index readback 2");

    // R4/R5 window routing
    for (int k = 0; k < 5; k++) begin
      hw_write(5'h04, codes[k]);
      win_write_chk(5'(5'h10 + k * 3), 8'h3C, 5'(1 << k), $sformatf("R4 route idx %0h", codes[k]));
      hw_read(5'h13, {4'(4'hA + k), 4'h3}, $sformatf("R5 read idx %0h", codes[k]));
      hw_read(5'h1F, {4'(4'hA + k), 4'hF}, $sformatf("R5 read top idx %0h", codes[k]));
    end

    // R6 undefined index values
    foreach (codes[i]) ; // keep codes used in loops only
    begin
      logic [7:0] undef [4] = '{8'h03, 8'h05, 8'h07, 8'h80};
      for (int u = 0; u < 4; u++) begin
        hw_write(5'h04, undef[u]);
        win_write_chk(5'h12, 8'h11, 5'h00, $sformatf("R6 no select idx %0h", undef[u]));
        hw_read(5'h1A, 8'hFF, $sformatf("R6 read idx %0h", undef[u]));
      end
    end

    // R7 status flags, active low
    hw_read(5'h02, 8'h07, "R7 none pending");
    src_xcvr = 1'b1;
    hw_read(5'h02, 8'h06, "R7 xcvr");
    src_xcvr = 1'b0; src_hdlc = 1'b1;
    hw_read(5'h02, 8'h05, "R7 hdlc");
    src_hdlc = 1'b0; src_timer = 1'b1;
    hw_read(5'h02, 8'h03, "R7 timer");
    src_xcvr = 1'b1; src_hdlc = 1'b1;
    hw_read(5'h02, 8'h00, "R7 all");
    src_xcvr = 1'b0; src_hdlc = 1'b0; src_timer = 1'b0;

    // R8 control 0 fields
    hw_write(5'h02, 8'h16);
    check("R8 fields a", {card_rst, timer_off, timer_clr, test_flag}, 4'b0111);
    hw_write(5'h02, 8'h01);
    check("R8 fields b", {card_rst, timer_off, timer_clr, test_flag}, 4'b1000);
    hw_write(5'h02, 8'h00);

    // R9 control 1
    hw_write(5'h03, 8'hFF);
    check("R9 outputs", {irq_line, serial_en}, 5'b11111);
    hw_read(5'h03, 8'h8F, "R9 readback");
    hw_write(5'h03, 8'h05);
    check("R9 outputs 2", {irq_line, serial_en}, 5'b01010);
    hw_read(5'h03, 8'h05, "R9 readback 2");

    // R10 interrupt timing and gating
    src_hdlc = 1'b1;
    @(negedge clk);
    check("R10 disabled", 32'(irq_out), 32'h0);
    hw_write(5'h02, 8'h08);
    check("R10 one cycle latency", 32'(irq_out), 32'h0);
    @(negedge clk);
    check("R10 asserted", 32'(irq_out), 32'h1);
    src_hdlc = 1'b0;
    @(negedge clk);
    check("R10 released", 32'(irq_out), 32'h0);
    src_timer = 1'b1;
    @(negedge clk);
    check("R10 timer source", 32'(irq_out), 32'h1);

    // R11 reset bit blocks interrupt
    hw_write(5'h02, 8'h09);
    src_xcvr = 1'b1;
    @(negedge clk);
    check("R11 held low", 32'(irq_out), 32'h0);
    @(negedge clk);
    check("R11 still low", 32'(irq_out), 32'h0);
    hw_write(5'h02, 8'h08);
    @(negedge clk);
    check("R11 released", 32'(irq_out), 32'h1);
    src_xcvr = 1'b0; src_timer = 1'b0;
    hw_write(5'h02, 8'h00);

    // R12 undefined config offsets
    hw_write(5'h04, 8'h02);
    hw_write(5'h07, 8'h55);
    hw_write(5'h0F, 8'hAA);
    hw_read(5'h07, 8'hFF, "R12 offset 7 reads FF");
    hw_read(5'h0C, 8'hFF, "R12 offset 12 reads FF");
    hw_read(5'h04, 8'h02, "R12 index untouched");
    hw_read(5'h03, 8'h05, "R12 ctl1 untouched");
    check("R12 ctl0 untouched", {card_rst, timer_off, timer_clr, test_flag}, 4'b0000);

    repeat (3) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule